// File: doc/BRIEF.md
# Request-Acknowledge Clock-Domain Bridge

This block moves one bus command at a time from a host clock domain into a system clock domain and brings the completion back. The host side raises a request for one cycle. With it comes a packed word holding a write flag, a read flag, a word address and write data. The block keeps that word in a host-domain register until the transaction is finished. Only a single toggle bit is passed through a synchroniser to the system side. There, an edge on the synchronised toggle starts a one-cycle write or read strobe on the system bus.

After a read strobe, the system side supplies its data one cycle later. The block captures that data and flips a return toggle. The return toggle travels back through a synchroniser, and its edge becomes a one-cycle acknowledge in the host domain. The captured word is presented as the response data, and it is already stable when the acknowledge appears. The host must wait for the acknowledge before it issues the next request.

Top module: `req_ack_bridge`

## Requirements
- R1: After either reset, h_ack, s_wr and s_rd are 0, and s_addr, s_wdata and h_rdata are all zero.
- R2: A write request produces exactly one s_wr cycle and no s_rd. During that cycle, s_addr and s_wdata carry the requested address and data.
- R3: A read request produces exactly one s_rd cycle with the requested address on s_addr and no s_wr. s_rd and s_wr are never high in the same cycle.
- R4: A read request leaves s_wdata unchanged; its data field is ignored.
- R5: For a read, h_rdata shows the value that s_rdata holds in the system cycle right after the s_rd cycle, and it does so by the cycle in which h_ack is high.
- R6: Each request yields exactly one h_ack, one host cycle wide. No acknowledge appears without an outstanding request, and no request is issued while one is outstanding.
- R7: A write request leaves h_rdata unchanged.
- R8: h_payload is laid out with the write flag in the top bit and the read flag one bit below it. The address sits in the next ADDR_W bits, and the data occupies the low DATA_W bits. Exactly one flag is set when h_req is high.
- R9: The payload is captured in the request cycle. Changes on h_payload after that cycle do not affect the transaction in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| h_clk | input | 1 | Host domain clock |
| h_rst_n | input | 1 | Host domain reset, active low, asynchronous |
| h_req | input | 1 | One-cycle request pulse |
| h_payload | input | ADDR_W+DATA_W+2 | Packed write flag, read flag, address, data |
| h_ack | output | 1 | One-cycle completion pulse |
| h_rdata | output | DATA_W | Response data returned with the acknowledge |
| s_clk | input | 1 | System domain clock |
| s_rst_n | input | 1 | System domain reset, active low, asynchronous |
| s_addr | output | ADDR_W | Transaction address |
| s_wr | output | 1 | One-cycle write strobe |
| s_wdata | output | DATA_W | Write data |
| s_rd | output | 1 | One-cycle read strobe |
| s_rdata | input | DATA_W | Read data, valid the cycle after s_rd |

## Verification
The two clocks run at unrelated periods. A table of reads and writes drives the bridge against a small register model on the system side. A read issued before any write tells the captured read data apart from a stale response. A read that follows a write to the same word shows that the address and data crossed correctly. All-ones and alternating address and data patterns expose swapped or shifted payload fields. Garbage placed on the payload right after each request, together with the check that s_wdata holds across reads, separates a captured payload from a live one. A reset in the middle of the run confirms that every output returns to zero.

// File: rtl/req_ack_bridge.sv
module req_ack_bridge #(
  parameter int ADDR_W      = 22,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     h_clk,
  input  logic                     h_rst_n,
  input  logic                     h_req,
  input  logic [ADDR_W+DATA_W+1:0] h_payload,
  output logic                     h_ack,
  output logic [DATA_W-1:0]        h_rdata,
  input  logic                     s_clk,
  input  logic                     s_rst_n,
  output logic [ADDR_W-1:0]        s_addr,
  output logic                     s_wr,
  output logic [DATA_W-1:0]        s_wdata,
  output logic                     s_rd,
  input  logic [DATA_W-1:0]        s_rdata
);
  localparam int PW    = ADDR_W + DATA_W + 2;
  localparam int WR_B  = PW - 1;
  localparam int RD_B  = PW - 2;

  // host domain
  logic [PW-1:0]          pay_q;
  logic                   req_tgl, busy;
  logic [SYNC_STAGES:0]   ack_sync;

  // system domain
  logic [SYNC_STAGES:0]   req_sync;
  logic                   req_edge, wr_q, rd_q, rd_late, ack_tgl;
  logic [ADDR_W-1:0]      addr_q;
  logic [DATA_W-1:0]      wdata_q, resp_q;

  always_ff @(posedge h_clk or negedge h_rst_n) begin
    if (!h_rst_n) begin
      pay_q    <= '0;
      req_tgl  <= 1'b0;
      busy     <= 1'b0;
      ack_sync <= '0;
    end else begin
      ack_sync <= {ack_sync[SYNC_STAGES-1:0], ack_tgl};
      if (h_req) begin
        pay_q   <= h_payload;
        req_tgl <= ~req_tgl;
      end
      if (h_req)      busy <= 1'b1;
      else if (h_ack) busy <= 1'b0;
    end
  end

  assign h_ack   = ack_sync[SYNC_STAGES] ^ ack_sync[SYNC_STAGES-1];
  assign h_rdata = resp_q;

  assign req_edge = req_sync[SYNC_STAGES] ^ req_sync[SYNC_STAGES-1];

  always_ff @(posedge s_clk or negedge s_rst_n) begin
    if (!s_rst_n) begin
      req_sync <= '0;
      wr_q     <= 1'b0;
      rd_q     <= 1'b0;
      rd_late  <= 1'b0;
      ack_tgl  <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
      resp_q   <= '0;
    end else begin
      req_sync <= {req_sync[SYNC_STAGES-1:0], req_tgl};
      wr_q     <= req_edge & pay_q[WR_B];
      rd_q     <= req_edge & pay_q[RD_B];
      rd_late  <= rd_q;
      if (req_edge)               addr_q  <= pay_q[DATA_W +: ADDR_W];
      if (req_edge & pay_q[WR_B]) wdata_q <= pay_q[DATA_W-1:0];
      if (rd_late)                resp_q  <= s_rdata;
      if (wr_q | rd_late)         ack_tgl <= ~ack_tgl;
    end
  end

  assign s_wr    = wr_q;
  assign s_rd    = rd_q;
  assign s_addr  = addr_q;
  assign s_wdata = wdata_q;

  // host-side checks
  p_one_flag_r8: assert property (@(posedge h_clk) disable iff (!h_rst_n)
    h_req |-> $countones(h_payload[WR_B:RD_B]) == 1);
  p_no_overlap_r6: assert property (@(posedge h_clk) disable iff (!h_rst_n)
    h_req |-> !busy);
  p_ack_pulse_r6: assert property (@(posedge h_clk) disable iff (!h_rst_n)
    h_ack |=> !h_ack);
  p_ack_owed_r6: assert property (@(posedge h_clk) disable iff (!h_rst_n)
    h_ack |-> busy);

  // system-side checks
  p_wr_pulse_r2: assert property (@(posedge s_clk) disable iff (!s_rst_n)
    s_wr |=> !s_wr);
  p_rd_pulse_r3: assert property (@(posedge s_clk) disable iff (!s_rst_n)
    s_rd |=> !s_rd);
  p_excl_r3: assert property (@(posedge s_clk) disable iff (!s_rst_n)
    $onehot0({s_wr, s_rd}));
  p_wdata_hold_r4: assert property (@(posedge s_clk) disable iff (!s_rst_n)
    s_rd |-> $stable(s_wdata));
endmodule

// File: tb/req_ack_bridge_test.sv
module req_ack_bridge_test;
  localparam int  AW      = 22;
  localparam int  DW      = 32;
  localparam time HCLK_P  = 10ns;
  localparam time SCLK_P  = 7ns;
  localparam int  NV      = 10;

  // {write, address, data}
  localparam logic [AW+DW:0] VEC [NV] = '{
    {1'b0, 22'h000003, 32'h0},
    {1'b1, 22'h3FFFFF, 32'hFFFF_FFFF},
    {1'b0, 22'h3FFFFF, 32'h0},
    {1'b1, 22'h000000, 32'h1234_5678},
    {1'b1, 22'h155555, 32'h0000_0000},
    {1'b0, 22'h000000, 32'hFFFF_FFFF},
    {1'b0, 22'h155555, 32'h5555_5555},
    {1'b1, 22'h2AAAAA, 32'hDEAD_BEEF},
    {1'b0, 22'h2AAAAA, 32'h0},
    {1'b0, 22'h000001, 32'h0}
  };

  logic h_clk = 0, s_clk = 0, h_rst_n = 0, s_rst_n = 0, h_req = 0;
  logic [AW+DW+1:0] h_payload = '0;
  logic h_ack, s_wr, s_rd;
  logic [DW-1:0] h_rdata, s_wdata, s_rdata;
  logic [AW-1:0] s_addr;

  int checks = 0, errors = 0;
  int wr_total = 0, rd_total = 0, ack_total = 0;
  logic [AW-1:0] mon_addr;
  logic [DW-1:0] mon_wdata, mon_wd_rd;
  logic [DW-1:0] mem [8];
  logic [DW-1:0] sh [8];

  always #(HCLK_P/2) h_clk = ~h_clk;
  always #(SCLK_P/2) s_clk = ~s_clk;

  req_ack_bridge #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .h_clk(h_clk), .h_rst_n(h_rst_n), .h_req(h_req), .h_payload(h_payload),
    .h_ack(h_ack), .h_rdata(h_rdata), .s_clk(s_clk), .s_rst_n(s_rst_n),
    .s_addr(s_addr), .s_wr(s_wr), .s_wdata(s_wdata), .s_rd(s_rd), .s_rdata(s_rdata));

  // system-side register model: read data valid the cycle after s_rd
  always @(posedge s_clk) begin
    if (!s_rst_n) begin
      for (int i = 0; i < 8; i++) mem[i] <= 32'hC0DE_0000 + 32'(i) * 32'h111;
      s_rdata <= '0;
    end else begin
      if (s_wr) mem[s_addr[2:0]] <= s_wdata;
      if (s_rd) s_rdata <= mem[s_addr[2:0]];
    end
  end

  always @(negedge s_clk) begin
    if (s_wr) begin wr_total++; mon_addr = s_addr; mon_wdata = s_wdata; end
    if (s_rd) begin rd_total++; mon_addr = s_addr; mon_wd_rd = s_wdata; end
  end

  always @(negedge h_clk) if (h_ack) ack_total++;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic shadow_init();
    for (int i = 0; i < 8; i++) sh[i] = 32'hC0DE_0000 + 32'(i) * 32'h111;
  endtask

  task automatic do_reset();
    @(negedge h_clk); h_rst_n = 0; s_rst_n = 0; h_req = 0;
    repeat (5) @(negedge h_clk);
    h_rst_n = 1; s_rst_n = 1;
    shadow_init();
    repeat (3) @(negedge h_clk);
    chk(h_ack == 0 && s_wr == 0 && s_rd == 0, "R1 strobes/ack", {h_ack, s_wr, s_rd}, 0);
    chk(s_addr == 0 && s_wdata == 0, "R1 addr/wdata", {s_addr, s_wdata}, 0);
    chk(h_rdata == 0, "R1 h_rdata", h_rdata, 0);
  endtask

  task automatic run_req(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    int w0 = wr_total, r0 = rd_total, k0 = ack_total;
    logic [DW-1:0] hr0 = h_rdata, wd0 = s_wdata, hr;
    bit seen = 0;
    @(negedge h_clk); h_payload = {wr, ~wr, a, d}; h_req = 1;
    @(negedge h_clk); h_req = 0; h_payload = {1'b1, 1'b1, ~a, ~d};
    for (int i = 0; i < 100 && !seen; i++) begin
      @(negedge h_clk);
      if (h_ack) seen = 1;
    end
    hr = h_rdata;
    chk(seen, "R6 ack arrives", seen, 1);
    @(negedge h_clk);
    chk(h_ack == 0, "R6 ack one cycle", h_ack, 0);
    repeat (4) @(negedge h_clk);
    chk(ack_total - k0 == 1, "R6 one ack per request", ack_total - k0, 1);
    chk(mon_addr == a, "R2 R3 R8 R9 address", mon_addr, a);
    if (wr) begin
      chk(wr_total - w0 == 1 && rd_total == r0, "R2 one write strobe",
          {wr_total - w0, rd_total - r0}, {32'd1, 32'd0});
      chk(mon_wdata == d, "R2 R9 write data", mon_wdata, d);
      chk(h_rdata == hr0, "R7 write leaves h_rdata", h_rdata, hr0);
      sh[a[2:0]] = d;
    end else begin
      chk(rd_total - r0 == 1 && wr_total == w0, "R3 one read strobe",
          {rd_total - r0, wr_total - w0}, {32'd1, 32'd0});
      chk(mon_wd_rd == wd0, "R4 read ignores data field", mon_wd_rd, wd0);
      chk(hr == sh[a[2:0]], "R5 read data at ack", hr, sh[a[2:0]]);
    end
  endtask

  initial begin
    #(HCLK_P * 150000);
    errors++; checks++;
    $display("FAIL R6 watchdog actual=hang expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    for (int v = 0; v < NV; v++)
      run_req(VEC[v][AW+DW], VEC[v][AW+DW-1:DW], VEC[v][DW-1:0]);
    // back-to-back corner: alternating write/read on one word
    run_req(1'b1, 22'h000004, 32'hA5A5_5A5A);
    run_req(1'b0, 22'h000004, 32'hFFFF_0000);
    run_req(1'b1, 22'h000004, 32'h0F0F_F0F0);
    run_req(1'b0, 22'h000004, 32'h0);
    // reset in the middle of the run, then a fresh read
    do_reset();
    run_req(1'b0, 22'h000006, 32'h0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule